// File: doc/BRIEF.md
# Audio serial clock generator

This block sits beside the serializers of a stereo serial audio port and turns the master audio clock into a bit clock and a frame clock. The frame clock is the left/right word select. The master audio clock is the block's own clock. In master mode it divides that clock down. The bit period is 2 or 4 master cycles. A frame is 32, 64 or 128 bit periods, split into two equal channel halves. Each clock has its own polarity control. The frame ratio and bit ratio are picked up only at a frame boundary, so a ratio change never produces a short pulse.

Alongside the clocks the block issues one-cycle strobes in the master clock domain. They mark the start of every bit (the edge where data changes), the middle of every bit (the sampling point) and the start of every frame, so the serializers need no edge detection of their own. A gating option lets the bit clock stand still while the serializers report no traffic. In slave mode the block does no dividing: it hands the externally supplied bit and frame clocks straight to its outputs and raises no strobes. With the global enable low every output is held low.

Top module: `audio_clkgen`

## Requirements
- R1: In master mode `bit_ratio_i` = 0 gives a bit period of 2 master cycles and `bit_ratio_i` = 1 gives 4 master cycles.
- R2: In master mode `frame_ratio_i` = 0, 1, 2 and 3 give frames of 32, 64, 128 and 128 bit periods respectively.
- R3: With `bclk_inv_i` = 0, `bclk_o` is low in the first half of every bit period and high in the second half, so data changes on its falling edge. With `bclk_inv_i` = 1 the levels are swapped.
- R4: The frame clock changes only at the start of a bit. With `fclk_inv_i` = 0, `fclk_o` is low for the first half of the frame (left channel) and high for the second half (right channel). Each half lasts half the frame ratio in bit periods. `fclk_inv_i` = 1 inverts it.
- R5: With `en_i` = 1 and `master_i` = 0, `bclk_o` follows `ext_bclk_i` and `fclk_o` follows `ext_fclk_i` with no register in the path, and all three strobes stay low.
- R6: With `nogate_i` = 1 the bit clock always runs. With `nogate_i` = 0 and `busy_i` = 0 at the start of a bit, `bclk_o` is held for that bit at the level opposite to `bclk_inv_i`. The frame clock and the strobes keep running.
- R7: With `en_i` = 0 all outputs are low from the second clock edge after `en_i` falls. In master mode the outputs first reflect the generator on the second clock edge after `en_i` is sampled high.
- R8: A change of `bit_ratio_i` or `frame_ratio_i` during a frame takes effect at the next frame start. The current frame finishes with the old ratios.
- R9: After enable, the first output cycle is the start of a frame and the start of its first bit, in the left half of the frame.
- R10: `launch_stb_o` is high for one master cycle at the start of every bit. `sample_stb_o` is high for one master cycle at mid-bit, the cycle in which the bit clock changes to its second-half level. `frame_stb_o` is high together with `launch_stb_o` on the first bit of each frame.
- R11: While reset is applied, and until the first enable, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable |
| master_i | input | 1 | 1: generate clocks, 0: pass external clocks |
| nogate_i | input | 1 | 1: bit clock runs continuously |
| busy_i | input | 1 | Serializers are moving data |
| bclk_inv_i | input | 1 | Bit clock polarity |
| fclk_inv_i | input | 1 | Frame clock polarity |
| bit_ratio_i | input | 1 | Bit period select (2 or 4 master cycles) |
| frame_ratio_i | input | 2 | Frame length select (32, 64, 128 bits) |
| ext_bclk_i | input | 1 | External bit clock (slave mode) |
| ext_fclk_i | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame clock |
| launch_stb_o | output | 1 | Bit start strobe |
| sample_stb_o | output | 1 | Mid-bit strobe |
| frame_stb_o | output | 1 | Frame start strobe |

## Verification
The properties check four things on every cycle: the strobe relations (a bit-start strobe never lasts two cycles, it never coincides with the mid-bit strobe, and every frame strobe comes with one), frame clock changes only at bit starts, silent strobes in slave mode and idle outputs once the enable has been low for two cycles. Whole-frame behaviour can only be shown by the bench scenarios: the exact bit and frame lengths for each ratio code, the two polarities, the in-phase start, gating that holds the bit clock level, and a ratio change that waits for the frame boundary. Each scenario compares every output cycle against a stream it computes in advance.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int unsigned BIT_FAST_DEF  = 2;
  localparam int unsigned BIT_SLOW_DEF  = 4;
  localparam int unsigned FRAME_S_DEF   = 32;
  localparam int unsigned FRAME_M_DEF   = 64;
  localparam int unsigned FRAME_L_DEF   = 128;
  localparam int unsigned FSEL_W        = 2;

  typedef enum logic [FSEL_W-1:0] {
    FSEL_SHORT = 2'd0,
    FSEL_MID   = 2'd1,
    FSEL_LONG  = 2'd2,
    FSEL_ALIAS = 2'd3
  } frame_sel_e;
endpackage

// File: rtl/aclk_ratio_latch.sv
module aclk_ratio_latch
  import aclk_pkg::*;
#(
  parameter int unsigned BIT_FAST = BIT_FAST_DEF,
  parameter int unsigned BIT_SLOW = BIT_SLOW_DEF,
  parameter int unsigned FRAME_S  = FRAME_S_DEF,
  parameter int unsigned FRAME_M  = FRAME_M_DEF,
  parameter int unsigned FRAME_L  = FRAME_L_DEF,
  localparam int unsigned SUB_W   = $clog2(BIT_SLOW),
  localparam int unsigned BIT_W   = $clog2(FRAME_L)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              frame_end_i,
  input  logic              bit_sel_i,
  input  logic [FSEL_W-1:0] frame_sel_i,
  output logic [SUB_W-1:0]  sub_last_o,
  output logic [SUB_W-1:0]  sub_half_o,
  output logic [BIT_W-1:0]  bit_last_o,
  output logic [BIT_W-1:0]  bit_half_o
);
  logic             load;
  logic [SUB_W-1:0] sub_last_d, sub_last_q;
  logic [BIT_W-1:0] bit_last_d, bit_last_q;
  frame_sel_e       fsel;

  assign fsel = frame_sel_e'(frame_sel_i);
  assign load = !run_i || frame_end_i;

  always_comb begin
    sub_last_d = sub_last_q;
    bit_last_d = bit_last_q;
    if (load) begin
      sub_last_d = bit_sel_i ? SUB_W'(BIT_SLOW - 1) : SUB_W'(BIT_FAST - 1);
      unique case (fsel)
        FSEL_SHORT: bit_last_d = BIT_W'(FRAME_S - 1);
        FSEL_MID:   bit_last_d = BIT_W'(FRAME_M - 1);
        default:    bit_last_d = BIT_W'(FRAME_L - 1);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_last_q <= SUB_W'(BIT_FAST - 1);
      bit_last_q <= BIT_W'(FRAME_S - 1);
    end else begin
      sub_last_q <= sub_last_d;
      bit_last_q <= bit_last_d;
    end
  end

  assign sub_last_o = sub_last_q;
  assign bit_last_o = bit_last_q;
  assign sub_half_o = (sub_last_q >> 1) + SUB_W'(1);
  assign bit_half_o = (bit_last_q >> 1) + BIT_W'(1);
endmodule

// File: rtl/aclk_bit_timer.sv
module aclk_bit_timer #(
  parameter int unsigned SUB_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SUB_W-1:0] sub_last_i,
  input  logic [SUB_W-1:0] sub_half_i,
  output logic             bit_end_o,
  output logic             raw_o,
  output logic             launch_o,
  output logic             sample_o
);
  logic [SUB_W-1:0] sub_d, sub_q;

  always_comb begin
    if (!run_i)                   sub_d = '0;
    else if (sub_q == sub_last_i) sub_d = '0;
    else                          sub_d = sub_q + SUB_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sub_q <= '0;
    else         sub_q <= sub_d;
  end

  assign bit_end_o = run_i && (sub_q == sub_last_i);
  assign raw_o     = (sub_q >= sub_half_i);
  assign launch_o  = run_i && (sub_q == '0);
  assign sample_o  = run_i && (sub_q == sub_half_i);
endmodule

// File: rtl/aclk_frame_timer.sv
module aclk_frame_timer #(
  parameter int unsigned BIT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bit_end_i,
  input  logic [BIT_W-1:0] bit_last_i,
  input  logic [BIT_W-1:0] bit_half_i,
  output logic             frame_end_o,
  output logic             right_o,
  output logic             first_o
);
  logic [BIT_W-1:0] bit_d, bit_q;
  logic             last_bit;

  assign last_bit = (bit_q == bit_last_i);

  always_comb begin
    if (!run_i)          bit_d = '0;
    else if (!bit_end_i) bit_d = bit_q;
    else if (last_bit)   bit_d = '0;
    else                 bit_d = bit_q + BIT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= '0;
    else         bit_q <= bit_d;
  end

  assign frame_end_o = bit_end_i && last_bit;
  assign right_o     = (bit_q >= bit_half_i);
  assign first_o     = (bit_q == '0);
endmodule

// File: rtl/aclk_out_stage.sv
module aclk_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic raw_i,
  input  logic right_i,
  input  logic launch_i,
  input  logic sample_i,
  input  logic first_i,
  input  logic bclk_inv_i,
  input  logic fclk_inv_i,
  input  logic nogate_i,
  input  logic busy_i,
  input  logic slave_i,
  input  logic ext_bclk_i,
  input  logic ext_fclk_i,
  output logic bclk_o,
  output logic fclk_o,
  output logic launch_o,
  output logic sample_o,
  output logic frame_o
);
  logic want_gate, gate_eff;
  logic gate_d, gate_q;
  logic bclk_d, bclk_q, fclk_d, fclk_q;
  logic launch_d, launch_q, sample_d, sample_q, frame_d, frame_q;

  assign want_gate = !nogate_i && !busy_i;
  assign gate_eff  = launch_i ? want_gate : gate_q;

  always_comb begin
    gate_d   = 1'b0;
    bclk_d   = 1'b0;
    fclk_d   = 1'b0;
    launch_d = 1'b0;
    sample_d = 1'b0;
    frame_d  = 1'b0;
    if (run_i) begin
      gate_d   = gate_eff;
      bclk_d   = gate_eff ? !bclk_inv_i : (raw_i ^ bclk_inv_i);
      fclk_d   = right_i ^ fclk_inv_i;
      launch_d = launch_i;
      sample_d = sample_i;
      frame_d  = launch_i && first_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q   <= 1'b0;
      bclk_q   <= 1'b0;
      fclk_q   <= 1'b0;
      launch_q <= 1'b0;
      sample_q <= 1'b0;
      frame_q  <= 1'b0;
    end else begin
      gate_q   <= gate_d;
      bclk_q   <= bclk_d;
      fclk_q   <= fclk_d;
      launch_q <= launch_d;
      sample_q <= sample_d;
      frame_q  <= frame_d;
    end
  end

  assign bclk_o   = slave_i ? ext_bclk_i : bclk_q;
  assign fclk_o   = slave_i ? ext_fclk_i : fclk_q;
  assign launch_o = launch_q;
  assign sample_o = sample_q;
  assign frame_o  = frame_q;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import aclk_pkg::*;
#(
  parameter int unsigned BIT_FAST = BIT_FAST_DEF,
  parameter int unsigned BIT_SLOW = BIT_SLOW_DEF,
  parameter int unsigned FRAME_S  = FRAME_S_DEF,
  parameter int unsigned FRAME_M  = FRAME_M_DEF,
  parameter int unsigned FRAME_L  = FRAME_L_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              nogate_i,
  input  logic              busy_i,
  input  logic              bclk_inv_i,
  input  logic              fclk_inv_i,
  input  logic              bit_ratio_i,
  input  logic [FSEL_W-1:0] frame_ratio_i,
  input  logic              ext_bclk_i,
  input  logic              ext_fclk_i,
  output logic              bclk_o,
  output logic              fclk_o,
  output logic              launch_stb_o,
  output logic              sample_stb_o,
  output logic              frame_stb_o
);
  localparam int unsigned SUB_W = $clog2(BIT_SLOW);
  localparam int unsigned BIT_W = $clog2(FRAME_L);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             run_d, run_q;
  logic [SUB_W-1:0] sub_last, sub_half;
  logic [BIT_W-1:0] bit_last, bit_half;
  logic             bit_end, raw, launch, sample;
  logic             frame_end, right, first;
  logic             slave;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign run_d = en_i && master_i;
  assign slave = en_i && !master_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  aclk_ratio_latch #(
    .BIT_FAST (BIT_FAST),
    .BIT_SLOW (BIT_SLOW),
    .FRAME_S  (FRAME_S),
    .FRAME_M  (FRAME_M),
    .FRAME_L  (FRAME_L)
  ) ratio_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run_q),
    .frame_end_i (frame_end),
    .bit_sel_i   (bit_ratio_i),
    .frame_sel_i (frame_ratio_i),
    .sub_last_o  (sub_last),
    .sub_half_o  (sub_half),
    .bit_last_o  (bit_last),
    .bit_half_o  (bit_half)
  );

  aclk_bit_timer #(.SUB_W(SUB_W)) bit_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (run_q),
    .sub_last_i (sub_last),
    .sub_half_i (sub_half),
    .bit_end_o  (bit_end),
    .raw_o      (raw),
    .launch_o   (launch),
    .sample_o   (sample)
  );

  aclk_frame_timer #(.BIT_W(BIT_W)) frame_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run_q),
    .bit_end_i   (bit_end),
    .bit_last_i  (bit_last),
    .bit_half_i  (bit_half),
    .frame_end_o (frame_end),
    .right_o     (right),
    .first_o     (first)
  );

  aclk_out_stage out_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (run_q),
    .raw_i      (raw),
    .right_i    (right),
    .launch_i   (launch),
    .sample_i   (sample),
    .first_i    (first),
    .bclk_inv_i (bclk_inv_i),
    .fclk_inv_i (fclk_inv_i),
    .nogate_i   (nogate_i),
    .busy_i     (busy_i),
    .slave_i    (slave),
    .ext_bclk_i (ext_bclk_i),
    .ext_fclk_i (ext_fclk_i),
    .bclk_o     (bclk_o),
    .fclk_o     (fclk_o),
    .launch_o   (launch_stb_o),
    .sample_o   (sample_stb_o),
    .frame_o    (frame_stb_o)
  );
endmodule

// File: rtl/aclk_checker.sv
module aclk_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_i,
  input logic fclk_inv_i,
  input logic bclk_o,
  input logic fclk_o,
  input logic launch_stb_o,
  input logic sample_stb_o,
  input logic frame_stb_o
);
  // R10: bit-start strobe lasts exactly one cycle
  a_r10_launch_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_stb_o |=> !launch_stb_o);

  // R10: bit start and mid-bit never coincide
  a_r10_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({launch_stb_o, sample_stb_o}));

  // R10: frame start is always a bit start
  a_r10_frame_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_o |-> launch_stb_o);

  // R4: with steady master operation the frame clock moves only at bit starts
  a_r4_fclk_at_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && $past(en_i) && $past(master_i) &&
     $past(en_i, 2) && $past(master_i, 2) &&
     ($past(fclk_inv_i) == $past(fclk_inv_i, 2)) && !$stable(fclk_o))
    |-> launch_stb_o);

  // R5: no strobes while in slave mode
  a_r5_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && $past(!master_i) && $past(!master_i, 2))
    |-> !(launch_stb_o || sample_stb_o || frame_stb_o));

  // R7: disabled block keeps every output low
  a_r7_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i) && $past(!en_i, 2))
    |-> !(bclk_o || fclk_o || launch_stb_o || sample_stb_o || frame_stb_o));
endmodule

bind audio_clkgen aclk_checker chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .master_i     (master_i),
  .fclk_inv_i   (fclk_inv_i),
  .bclk_o       (bclk_o),
  .fclk_o       (fclk_o),
  .launch_stb_o (launch_stb_o),
  .sample_stb_o (sample_stb_o),
  .frame_stb_o  (frame_stb_o)
);

// File: tb/audio_clkgen_tb_top.sv
`timescale 1ns/1ps
module audio_clkgen_tb_top;
  logic       clk;
  logic       rst_n;
  logic       en, master, nogate, busy, binv, finv, bsel;
  logic [1:0] fsel;
  logic       xb, xf;
  logic       bclk, fclk, lstb, sstb, fstb;

  int n_checks = 0;
  int n_errs   = 0;
  bit mon_on   = 0;
  bit done     = 0;

  typedef struct {
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  audio_clkgen dut_i (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .master_i (master),
    .nogate_i (nogate), .busy_i (busy), .bclk_inv_i (binv), .fclk_inv_i (finv),
    .bit_ratio_i (bsel), .frame_ratio_i (fsel),
    .ext_bclk_i (xb), .ext_fclk_i (xf),
    .bclk_o (bclk), .fclk_o (fclk), .launch_stb_o (lstb),
    .sample_stb_o (sstb), .frame_stb_o (fstb)
  );

  task automatic check(input logic [4:0] got, input logic [4:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s: got %b expected %b (bclk fclk launch sample frame)", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  // monitor: pops one expected item per master cycle
  always @(negedge clk) begin
    if (mon_on && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({bclk, fclk, lstb, sstb, fstb}, e.v, e.tag);
    end
  end

  // driver side: expected stream for one frame of m master cycles per bit, f bits
  task automatic push_frame(input int m, input int f, input logic ci, input logic li,
                            input logic gated, input string tag);
    for (int t = 0; t < m * f; t++) begin
      exp_t e;
      int sub, bt;
      logic b, fr;
      sub = t % m;
      bt  = t / m;
      b   = gated ? !ci : (((sub >= m / 2) ? 1'b1 : 1'b0) ^ ci);
      fr  = ((bt >= f / 2) ? 1'b1 : 1'b0) ^ li;
      e.v = {b, fr, (sub == 0), (sub == m / 2), (t == 0)};
      e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  function automatic int flen(input logic [1:0] s);
    return (s == 2'd0) ? 32 : (s == 2'd1) ? 64 : 128;
  endfunction

  // master-mode scenario; the new ratio is applied during frame 0
  task automatic run_master(input logic b0, input logic [1:0] f0, input logic b1,
                            input logic [1:0] f1, input int nfr, input logic ci,
                            input logic li, input logic ng, input logic bz,
                            input string tag);
    logic gated;
    @(negedge clk);
    gated = !ng && !bz;
    bsel = b0; fsel = f0; binv = ci; finv = li; nogate = ng; busy = bz;
    master = 1'b1; en = 1'b1;
    push_frame(b0 ? 4 : 2, flen(f0), ci, li, gated, tag);
    for (int k = 1; k < nfr; k++)
      push_frame(b1 ? 4 : 2, flen(f1), ci, li, gated, tag);
    @(posedge clk);
    @(posedge clk);
    mon_on = 1;
    repeat (5) @(negedge clk);
    bsel = b1; fsel = f1;
    wait (sb_q.size() == 0);
    mon_on = 0;
    en = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check({bclk, fclk, lstb, sstb, fstb}, 5'b0, "R7 off after disable");
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; master = 1'b1; nogate = 1'b1; busy = 1'b1;
    binv = 1'b0; finv = 1'b0; bsel = 1'b0; fsel = 2'd0; xb = 1'b1; xf = 1'b1;
    repeat (3) @(negedge clk);
    check({bclk, fclk, lstb, sstb, fstb}, 5'b0, "R11 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({bclk, fclk, lstb, sstb, fstb}, 5'b0, "R11 after reset");

    run_master(1'b0, 2'd0, 1'b0, 2'd0, 2, 1'b0, 1'b0, 1'b1, 1'b1, "R1 R2 R3 R9 R10 r2/32");
    run_master(1'b1, 2'd1, 1'b1, 2'd1, 2, 1'b1, 1'b1, 1'b1, 1'b1, "R1 R3 R4 r4_inv 4/64");
    run_master(1'b0, 2'd2, 1'b0, 2'd3, 2, 1'b0, 1'b1, 1'b1, 1'b1, "R2 codes 2 and 3");
    run_master(1'b0, 2'd0, 1'b1, 2'd1, 3, 1'b0, 1'b0, 1'b1, 1'b1, "R8 ratio change");
    run_master(1'b1, 2'd0, 1'b1, 2'd0, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 gated ckp0");
    run_master(1'b0, 2'd0, 1'b0, 2'd0, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 gated ckp1");
    run_master(1'b0, 2'd0, 1'b0, 2'd0, 1, 1'b0, 1'b0, 1'b0, 1'b1, "R6 busy runs");

    // R5: slave pass-through
    @(negedge clk);
    master = 1'b0; en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      xb = k[0]; xf = k[1];
      #1;
      check({bclk, fclk, lstb, sstb, fstb}, {k[0], k[1], 3'b000}, "R5 slave path");
      @(negedge clk);
      check({bclk, fclk, lstb, sstb, fstb}, {k[0], k[1], 3'b000}, "R5 slave no strobes");
    end

    // R7: disabled with external clocks high
    xb = 1'b1; xf = 1'b1; en = 1'b0;
    #1;
    check({bclk, fclk, lstb, sstb, fstb}, 5'b0, "R7 slave disabled");
    repeat (3) @(negedge clk);
    check({bclk, fclk, lstb, sstb, fstb}, 5'b0, "R7 stays idle");
    summary();
  end

  initial begin
    #(200000 * 20);
    n_errs++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule